// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an on-chip request port and an external byte-wide asynchronous static RAM with a 17-bit address. It turns each single-byte request into a correctly timed pin sequence. The port signals are the address, two chip selects of opposite polarity (an active-low one and an active-high one), an active-low write strobe, an active-low output enable, and a bidirectional data bus. The data bus is split into a driven value, a sampled value and a driver enable. A request is taken with a valid/ready handshake. A read returns its byte on a one-cycle response pulse.

All memory timing is met by counting system clock cycles. The read access time, the write strobe width and the bus turnaround after a read are parameters (`RD_CYC`, `WE_CYC`, `TA_CYC`, each at least 1). At a 100 MHz clock the defaults of 2, 2 and 1 cycles exceed a 10 ns access part's minimums. The bus is driven only while the write strobe is low. The output enable is never asserted during a write. The chip is deselected for the turnaround after every read, so the controller's driver and the memory's driver never overlap.

The state machine has six states:
- IDLE: accepts a request.
- RD_ACCESS: the chip is selected with the output enable low.
- RD_TURN: the chip is deselected while the memory's outputs float.
- WR_SETUP: the address and selects are driven with the strobe high.
- WR_STROBE: the strobe is low and the data is driven.
- WR_RECOVER: the strobe is high, and the address and selects are held.

The transitions are:
- IDLE→RD_ACCESS on an accepted read.
- IDLE→WR_SETUP on an accepted write.
- RD_ACCESS→RD_TURN when the access count expires, with the data captured on that edge.
- RD_TURN→IDLE when the gap count expires.
- WR_SETUP→WR_STROBE after one cycle.
- WR_STROBE→WR_RECOVER when the strobe count expires.
- WR_RECOVER→IDLE after one cycle.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: `req_ready` is high only in IDLE. A read keeps it low for RD_CYC+TA_CYC cycles after acceptance, and a write keeps it low for WE_CYC+2 cycles.
- R3: A read holds the chip selected (`mem_cs1_n`=0, `mem_cs2`=1) with `mem_oe_n`=0 for exactly RD_CYC cycles. The byte on `mem_dq_in` at the last clock edge of that window is the returned data.
- R4: `rsp_valid` is high for exactly one cycle, starting RD_CYC cycles after the accepting edge, with the read byte on `rsp_rdata`. Writes produce no response.
- R5: A write selects the chip with the strobe high for one cycle. It then holds `mem_we_n`=0 for exactly WE_CYC cycles, then keeps the chip selected with the strobe high for one more cycle. `mem_addr` is constant throughout.
- R6: `mem_dq_oe` is high only while `mem_we_n` is low, and then `mem_dq_out` equals the write byte.
- R7: After a read, the chip stays deselected with `mem_oe_n`=1 for TA_CYC cycles before the next request can be accepted.
- R8: Outside an access the chip is deselected, with `mem_we_n`=1 and `mem_oe_n`=1.
- R9: `mem_oe_n` and `mem_we_n` are never low together.
- R10: Request fields are used only at the accepting edge. Changes to `req_addr`, `req_wdata` or `req_write` afterwards do not alter `mem_addr`, the driven byte or the cycle type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 17 | Memory address pins |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_in | input | 8 | Byte sampled from the data bus |
| mem_dq_oe | output | 1 | Controller data driver enable |

## Verification
A wrong state or counter value shows within one cycle on the pins. A strobe that is too long or too short changes the number of low cycles on `mem_we_n` or `mem_oe_n`. A skipped turnaround shortens the deselected gap and the busy time seen on `req_ready`. A capture on the wrong edge returns a stale byte at the response pulse. The bench writes a distinct byte to each of 256 addresses and reads every one back. It also runs alternating write/read pairs. It measures each pin window against the parameters, and a bus model counts any cycle in which both sides drive.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RD_ACCESS  = 3'd1,
        ST_RD_TURN    = 3'd2,
        ST_WR_SETUP   = 3'd3,
        ST_WR_STROBE  = 3'd4,
        ST_WR_RECOVER = 3'd5
    } ctrl_state_t;

    function automatic int unsigned cnt_width(input int unsigned a,
                                              input int unsigned b,
                                              input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return (m <= 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/sram_ctrl_reqreg.sv
module sram_ctrl_reqreg #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic [ADDR_W-1:0] held_addr,
    output logic [DATA_W-1:0] held_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr <= '0;
            held_data <= '0;
        end else if (take) begin
            held_addr <= in_addr;
            held_data <= in_data;
        end
    end
endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grab,
    input  logic [DATA_W-1:0] bus_in,
    output logic              pulse,
    output logic [DATA_W-1:0] byte_out
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse    <= 1'b0;
            byte_out <= '0;
        end else begin
            pulse <= grab;
            if (grab) begin
                byte_out <= bus_in;
            end
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned RD_CYC = 2,
    parameter int unsigned WE_CYC = 2,
    parameter int unsigned TA_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int unsigned CNT_W = cnt_width(RD_CYC, WE_CYC, TA_CYC);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WE_LOAD = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);

    ctrl_state_t      state, state_nx;
    logic             accept;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;
    logic             grab;

    assign accept = req_valid && req_ready;

    // next-state and counter-load decisions
    always_comb begin
        state_nx = state;
        t_load   = 1'b0;
        t_val    = '0;
        grab     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_nx = ST_WR_SETUP;
                    end else begin
                        state_nx = ST_RD_ACCESS;
                        t_load   = 1'b1;
                        t_val    = RD_LOAD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (t_done) begin
                    grab     = 1'b1;
                    state_nx = ST_RD_TURN;
                    t_load   = 1'b1;
                    t_val    = TA_LOAD;
                end
            end
            ST_RD_TURN: begin
                if (t_done) state_nx = ST_IDLE;
            end
            ST_WR_SETUP: begin
                state_nx = ST_WR_STROBE;
                t_load   = 1'b1;
                t_val    = WE_LOAD;
            end
            ST_WR_STROBE: begin
                if (t_done) state_nx = ST_WR_RECOVER;
            end
            ST_WR_RECOVER: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // pin levels decoded from the current state
    logic sel;
    always_comb begin
        sel       = 1'b0;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        req_ready = 1'b0;
        unique case (state)
            ST_IDLE:       req_ready = 1'b1;
            ST_RD_ACCESS: begin
                sel      = 1'b1;
                mem_oe_n = 1'b0;
            end
            ST_RD_TURN:    ;
            ST_WR_SETUP:   sel = 1'b1;
            ST_WR_STROBE: begin
                sel       = 1'b1;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_RECOVER: sel = 1'b1;
            default:       ;
        endcase
        mem_cs1_n = ~sel;
        mem_cs2   = sel;
    end

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_done)
    );

    sram_ctrl_reqreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (accept),
        .in_addr   (req_addr),
        .in_data   (req_wdata),
        .held_addr (mem_addr),
        .held_data (mem_dq_out)
    );

    sram_ctrl_rdcap #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .grab     (grab),
        .bus_in   (mem_dq_in),
        .pulse    (rsp_valid),
        .byte_out (rsp_rdata)
    );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int unsigned ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs1_n,
    input logic              mem_cs2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    logic selected;
    assign selected = !mem_cs1_n && mem_cs2;

    AST_NO_OE_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n)); // R9
    AST_DRIVE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && selected)); // R6
    AST_STROBE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> selected); // R8
    AST_ADDR_HELD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr)); // R5
    AST_SETUP_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(selected) && $stable(mem_addr))); // R5
    AST_RECOVER_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (selected && $stable(mem_addr))); // R5
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R4
    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!selected && mem_we_n && mem_oe_n)); // R2
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (!selected && !req_ready)); // R7
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs1_n (mem_cs1_n),
    .mem_cs2   (mem_cs2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int RD = 2;
    localparam int WE = 2;
    localparam int TA = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    int nchk = 0;
    int nfail = 0;
    int clash = 0;
    bit done = 1'b0;

    logic [DW-1:0] model [256];

    always #4 clk = ~clk;

    sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WE_CYC(WE), .TA_CYC(TA)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    // memory model: drives when selected, output enabled and not writing
    wire sel = (mem_cs1_n === 1'b0) && (mem_cs2 === 1'b1);
    wire mem_drv = sel && (mem_oe_n === 1'b0) && (mem_we_n === 1'b1);
    assign mem_dq_in = mem_drv ? model[mem_addr[7:0]] : 8'h00;

    always @(posedge mem_we_n) begin
        if (sel) model[mem_addr[7:0]] = mem_dq_out;
    end

    always @(negedge clk) begin
        if (rst_n && mem_drv && mem_dq_oe) clash++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] addr_of(input int i);
        logic [7:0] b = 8'(i);
        return {b, b[0], b};
    endfunction

    function automatic logic [DW-1:0] data_of(input int i, input int salt);
        return 8'((i * 73 + 11 + salt * 29) & 255);
    endfunction

    task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [DW-1:0] exp_rd);
        int n = 0, busy = 0, rsp_at = 0, rsp_cnt = 0;
        int we_lo = 0, oe_lo = 0, drv = 0, drv_bad = 0, gap = 0;
        int addr_bad = 0, first_sel = 0, last_sel = 0;
        logic [DW-1:0] got = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                // R10: scramble the request fields after acceptance
                req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
            end
            if (!req_ready) busy++;
            if (rsp_valid) begin
                rsp_cnt++;
                if (rsp_at == 0) rsp_at = n;
                got = rsp_rdata;
            end
            if (!mem_we_n) we_lo++;
            if (!mem_oe_n) oe_lo++;
            if (mem_dq_oe) begin
                drv++;
                if (mem_we_n || mem_dq_out !== d) drv_bad++;
            end
            if (sel && mem_addr !== a) addr_bad++;
            if (!sel && !req_ready) gap++;
            if (n == 1) first_sel = sel && mem_we_n;
            if (!req_ready) last_sel = sel && mem_we_n;
        end while (!req_ready && n < 64);
        check(!sel && mem_we_n && mem_oe_n && !mem_dq_oe, "R8", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n}, 4'b1011);
        check(addr_bad == 0, "R10", addr_bad, 0);
        if (wr) begin
            check(busy == WE + 2, "R2", busy, WE + 2);
            check(we_lo == WE, "R5", we_lo, WE);
            check(first_sel == 1 && last_sel == 1, "R5", {first_sel, last_sel}, 2'b11);
            check(oe_lo == 0, "R9", oe_lo, 0);
            check(drv == WE && drv_bad == 0, "R6", drv, WE);
            check(rsp_cnt == 0, "R4", rsp_cnt, 0);
        end else begin
            check(busy == RD + TA, "R2", busy, RD + TA);
            check(oe_lo == RD, "R3", oe_lo, RD);
            check(we_lo == 0 && drv == 0, "R9", we_lo + drv, 0);
            check(rsp_cnt == 1 && rsp_at == RD + 1, "R4", rsp_at, RD + 1);
            check(got == exp_rd, "R3", got, exp_rd);
            check(gap == TA, "R7", gap, TA);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset levels while reset is held
        check(mem_cs1_n === 1'b1 && mem_cs2 === 1'b0 && mem_we_n === 1'b1 && mem_oe_n === 1'b1,
              "R1", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n}, 4'b1011);
        check(mem_dq_oe === 1'b0 && rsp_valid === 1'b0 && req_ready === 1'b1, "R1",
              {mem_dq_oe, rsp_valid, req_ready}, 3'b001);
        rst_n = 1'b1;
        // sweep: distinct byte into each of 256 addresses, then read all back
        for (int i = 0; i < 256; i++) xfer(1'b1, addr_of(i), data_of(i, 0), '0);
        for (int i = 0; i < 256; i++) xfer(1'b0, addr_of(i), '0, data_of(i, 0));
        // alternating write then immediate read of the same location
        for (int i = 0; i < 64; i++) begin
            xfer(1'b1, addr_of(i * 4 + 1), data_of(i, 3), '0);
            xfer(1'b0, addr_of(i * 4 + 1), '0, data_of(i, 3));
        end
        // read then write back-to-back to exercise turnaround before driving
        for (int i = 0; i < 16; i++) begin
            xfer(1'b0, addr_of(i * 4 + 1), '0, data_of(i, 3));
            xfer(1'b1, addr_of(i * 4 + 2), data_of(i, 7), '0);
            xfer(1'b0, addr_of(i * 4 + 2), '0, data_of(i, 7));
        end
        check(clash == 0, "R6", clash, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule